// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block receives control words over a write-only three-wire serial port (a bit clock, a data line and a latch line) and keeps the control state of a six-channel audio converter. The three serial lines are asynchronous to the core clock. They pass through a short synchronizer and are edge-detected in the core clock domain. Each rising edge of the bit clock shifts one data bit in. A rising edge of the latch line then commits the frame to the addressed register.

Each frame carries a 4-bit address and a 9-bit data field. Six addresses set the attenuation of the six channels. Each attenuation write either changes the active level or is held back, depending on a load flag. A master address sets all six channels in one write. A link flag makes the right channel of each converter pair follow the left channel of the same pair. Two further addresses hold the general controls: soft mute, de-emphasis, operation disable, word length, output routing, data format, frame-clock polarity, sample-rate group and zero-detect enable. These drive the datapath directly.

Top module: `ctl3w_regs`

## Requirements
- R1: While reset is low, and right after it is released, all six attenuation codes read FF, the routing code reads 4'b1001, and every other control output reads 0.
- R2: A frame is the last 16 bits sampled on rising bit-clock edges, MSB first. Frame bits 15:13 are ignored, bits 12:9 form the address and bits 8:0 form the data. A rising latch edge commits the frame. Outside a commit, no output changes.
- R3: An attenuation write with data bit 8 set makes data bits 7:0 the active code of its channel. Addresses 0, 1, 4, 5, 6 and 7 map to channels 0 to 5, and channel c sits at att_code[8c+7:8c]. Even channels are the left channels and odd channels the right channels of pairs 0, 1 and 2.
- R4: An attenuation write with data bit 8 clear leaves every active code unchanged.
- R5: A write to address 8 with data bit 8 set makes data bits 7:0 the active code of all six channels. With bit 8 clear it changes nothing.
- R6: While the link flag is 1, each odd channel outputs the active code of the even channel below it. Clearing the flag restores the odd channel's own active code.
- R7: A write to address 2 sets mute from bit 0, de-emphasis from bit 1, operation disable from bit 2, word length from bits 4:3 and routing from bits 8:5.
- R8: A write to address 3 sets format select from bit 0, frame-clock polarity from bit 1, the link flag from bit 2, sample-rate group from bits 7:6 and zero-detect enable from bit 8. Bits 5:3 are ignored.
- R9: Writes to addresses 9 to 15 change no output.
- R10: A latch edge that follows fewer than 16 bit-clock edges since the previous latch edge (or since reset) commits nothing.
- R11: Pulling reset low at any time returns all outputs to the R1 values at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Serial bit clock, asynchronous |
| ctl_dat | input | 1 | Serial data, sampled on rising ctl_clk |
| ctl_lat | input | 1 | Latch; a rising edge commits the frame |
| att_code | output | 48 | Six effective 8-bit attenuation codes, channel c at [8c+7:8c], FF = 0 dB, 00 = full mute |
| mute | output | 1 | Soft mute request |
| deemph | output | 1 | De-emphasis enable |
| op_disable | output | 1 | Converter operation disable |
| word_len | output | 2 | Input word length code |
| route | output | 4 | Output routing code |
| fmt_sel | output | 1 | Serial audio format select |
| lr_pol | output | 1 | Frame-clock polarity |
| rate_grp | output | 2 | Sample-rate group |
| zero_det_en | output | 1 | Zero-detect automute enable |

## Verification
If the bit counter, the shift register or the address decode went wrong, a register other than the addressed one would change, or the addressed one would be missed. The control outputs show this about three core cycles after the latch edge. Active attenuation codes are held state, so a wrong load decision stays on att_code until that channel is next written with its load flag set. The bench therefore compares the whole output state after every frame. Pending-versus-active errors and link errors also show up in the untouched channels of the same pair.

// File: rtl/ctl3w_regs.sv
module ctl3w_regs #(
  parameter int FRAME_W       = 16,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 9,
  parameter int ATT_W         = 8,
  parameter int NUM_PAIRS     = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int CTRL_ADDR     = 2,
  parameter int FMT_ADDR      = 3,
  parameter int MASTER_ADDR   = 8,
  parameter logic [3:0] ROUTE_RST = 4'b1001
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_clk,
  input  logic                       ctl_dat,
  input  logic                       ctl_lat,
  output logic [2*NUM_PAIRS*ATT_W-1:0] att_code,
  output logic                       mute,
  output logic                       deemph,
  output logic                       op_disable,
  output logic [1:0]                 word_len,
  output logic [3:0]                 route,
  output logic                       fmt_sel,
  output logic                       lr_pol,
  output logic [1:0]                 rate_grp,
  output logic                       zero_det_en
);
  localparam int NUM_CH   = 2 * NUM_PAIRS;
  localparam int SHIFT_W  = ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int LOAD_BIT = DATA_W - 1;
  localparam int TOP      = SYNC_STAGES - 1;

  function automatic logic [ADDR_W-1:0] ch_addr(input int c);
    int p;
    int s;
    p = c / 2;
    s = c % 2;
    return ADDR_W'((p == 0) ? s : 2 + 2 * p + s);
  endfunction

  logic [SYNC_STAGES-1:0] clk_s, dat_s, lat_s;
  logic                   clk_q, lat_q;
  logic                   clk_rise, lat_rise;
  logic [SHIFT_W-1:0]     shreg;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   commit;
  logic [ADDR_W-1:0]      f_addr;
  logic [DATA_W-1:0]      f_data;
  logic                   f_load;
  logic                   link;
  logic [ATT_W-1:0]       act [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      dat_s <= '0;
      lat_s <= '0;
      clk_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      clk_s <= {clk_s[SYNC_STAGES-2:0], ctl_clk};
      dat_s <= {dat_s[SYNC_STAGES-2:0], ctl_dat};
      lat_s <= {lat_s[SYNC_STAGES-2:0], ctl_lat};
      clk_q <= clk_s[TOP];
      lat_q <= lat_s[TOP];
    end
  end

  assign clk_rise = clk_s[TOP] & ~clk_q;
  assign lat_rise = lat_s[TOP] & ~lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      if (clk_rise)
        shreg <= {shreg[SHIFT_W-2:0], dat_s[TOP]};
      if (lat_rise)
        bit_cnt <= '0;
      else if (clk_rise && bit_cnt != CNT_W'(FRAME_W))
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = lat_rise && (bit_cnt == CNT_W'(FRAME_W));
  assign f_addr = shreg[SHIFT_W-1 -: ADDR_W];
  assign f_data = shreg[DATA_W-1:0];
  assign f_load = f_data[LOAD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) act[c] <= '1;
      {route, word_len, op_disable, deemph, mute} <= {ROUTE_RST, 5'b0};
      fmt_sel     <= 1'b0;
      lr_pol      <= 1'b0;
      link        <= 1'b0;
      rate_grp    <= 2'b0;
      zero_det_en <= 1'b0;
    end else if (commit) begin
      for (int c = 0; c < NUM_CH; c++)
        if (f_load && (f_addr == ch_addr(c) || f_addr == ADDR_W'(MASTER_ADDR)))
          act[c] <= f_data[ATT_W-1:0];
      if (f_addr == ADDR_W'(CTRL_ADDR))
        {route, word_len, op_disable, deemph, mute} <= f_data;
      if (f_addr == ADDR_W'(FMT_ADDR)) begin
        fmt_sel     <= f_data[0];
        lr_pol      <= f_data[1];
        link        <= f_data[2];
        rate_grp    <= f_data[7:6];
        zero_det_en <= f_data[8];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c % 2 == 1) begin : g_right
      assign att_code[c*ATT_W +: ATT_W] = link ? act[c-1] : act[c];
    end else begin : g_left
      assign att_code[c*ATT_W +: ATT_W] = act[c];
    end
  end
endmodule

// File: rtl/ctl3w_regs_chk.sv
module ctl3w_regs_chk #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 9,
  parameter int ATT_W       = 8,
  parameter int NUM_CH      = 6,
  parameter int CTRL_ADDR   = 2,
  parameter int FMT_ADDR    = 3,
  parameter int MASTER_ADDR = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    commit,
  input logic [ADDR_W-1:0]       f_addr,
  input logic [DATA_W-1:0]       f_data,
  input logic [NUM_CH*ATT_W-1:0] att_code,
  input logic [14:0]             ctrl_bus
);
  function automatic logic all_eq(input logic [NUM_CH*ATT_W-1:0] v, input logic [ATT_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NUM_CH; c++)
      if (v[c*ATT_W +: ATT_W] != x) ok = 1'b0;
    return ok;
  endfunction

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (att_code == '1 && ctrl_bus == 15'h0120)); // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(att_code) && $stable(ctrl_bus))); // R2

  AST_DEFERRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !f_data[DATA_W-1] && f_addr != ADDR_W'(CTRL_ADDR) && f_addr != ADDR_W'(FMT_ADDR))
    |=> $stable(att_code)); // R4

  AST_MASTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && f_data[DATA_W-1] && f_addr == ADDR_W'(MASTER_ADDR))
    |=> all_eq(att_code, $past(f_data[ATT_W-1:0]))); // R5

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && f_addr > ADDR_W'(MASTER_ADDR))
    |=> ($stable(att_code) && $stable(ctrl_bus))); // R9
endmodule

bind ctl3w_regs ctl3w_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATT_W(ATT_W), .NUM_CH(NUM_CH),
  .CTRL_ADDR(CTRL_ADDR), .FMT_ADDR(FMT_ADDR), .MASTER_ADDR(MASTER_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .f_addr(f_addr), .f_data(f_data),
  .att_code(att_code),
  .ctrl_bus({zero_det_en, rate_grp, lr_pol, fmt_sel, link, route, word_len, op_disable, deemph, mute})
);

// File: tb/ctl3w_regs_tb.sv
module ctl3w_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat = 1'b0;
  logic [47:0] att_code;
  logic mute, deemph, op_disable, fmt_sel, lr_pol, zero_det_en;
  logic [1:0] word_len, rate_grp;
  logic [3:0] route;

  always #10 clk = ~clk;

  ctl3w_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_lat(ctl_lat),
    .att_code(att_code), .mute(mute), .deemph(deemph), .op_disable(op_disable),
    .word_len(word_len), .route(route), .fmt_sel(fmt_sel), .lr_pol(lr_pol),
    .rate_grp(rate_grp), .zero_det_en(zero_det_en)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] m_act [6];
  logic m_mute, m_de, m_op, m_fmt, m_pol, m_link, m_zd;
  logic [1:0] m_wl, m_rate;
  logic [3:0] m_route;

  task automatic model_reset();
    for (int c = 0; c < 6; c++) m_act[c] = 8'hFF;
    {m_mute, m_de, m_op, m_fmt, m_pol, m_link, m_zd} = '0;
    m_wl = 2'd0; m_rate = 2'd0; m_route = 4'b1001;
  endtask

  task automatic model_write(input int addr, input logic [8:0] d);
    case (addr)
      0, 1, 4, 5, 6, 7: if (d[8]) m_act[(addr < 2) ? addr : addr - 2] = d[7:0];
      8: if (d[8]) for (int c = 0; c < 6; c++) m_act[c] = d[7:0];
      2: begin m_mute = d[0]; m_de = d[1]; m_op = d[2]; m_wl = d[4:3]; m_route = d[8:5]; end
      3: begin m_fmt = d[0]; m_pol = d[1]; m_link = d[2]; m_rate = d[7:6]; m_zd = d[8]; end
      default: ;
    endcase
  endtask

  function automatic logic [47:0] exp_att();
    logic [47:0] v;
    for (int c = 0; c < 6; c++)
      v[c*8 +: 8] = (c % 2 == 1 && m_link) ? m_act[c-1] : m_act[c];
    return v;
  endfunction

  task automatic check(input string req);
    logic [13:0] act_c, exp_c;
    logic [47:0] ea;
    ea = exp_att();
    act_c = {zero_det_en, rate_grp, lr_pol, fmt_sel, route, word_len, op_disable, deemph, mute};
    exp_c = {m_zd, m_rate, m_pol, m_fmt, m_route, m_wl, m_op, m_de, m_mute};
    n_vec++;
    if (att_code !== ea || act_c !== exp_c) begin
      n_bad++;
      $display("FAIL %s att=%h ctrl=%h expected att=%h ctrl=%h", req, att_code, act_c, ea, exp_c);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_dat = w[i]; ctl_clk = 1'b0; wait_clk(3);
      ctl_clk = 1'b1; wait_clk(3);
    end
    ctl_clk = 1'b0; wait_clk(3);
    ctl_lat = 1'b1; wait_clk(4);
    ctl_lat = 1'b0; wait_clk(4);
    @(negedge clk);
  endtask

  task automatic write(input int addr, input logic [8:0] d);
    send_bits({16'h0, 3'b101, 4'(addr), d}, 16);
    model_write(addr, d);
  endtask

  initial begin
    model_reset();
    wait_clk(5);
    @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    wait_clk(2); @(negedge clk);
    check("R1 after reset");

    for (int c = 0; c < 6; c++) begin
      write((c < 2) ? c : c + 2, {1'b1, 8'(8'h11 * c + 3)});
      check("R3 load write");
    end
    for (int c = 0; c < 6; c++) begin
      write((c < 2) ? c : c + 2, {1'b0, 8'(8'h5A ^ c)});
      check("R4 deferred write");
    end
    write(8, 9'h0A7);
    check("R5 master no load");
    foreach (m_act[i]) ;
    for (int v = 0; v < 3; v++) begin
      write(8, {1'b1, 8'(v * 8'h7F + v)});
      check("R5 master load");
    end
    for (int c = 0; c < 6; c++) write((c < 2) ? c : c + 2, {1'b1, 8'(8'h20 + 8'h25 * c)});
    check("R3 distinct codes");
    write(3, 9'h004);
    check("R6 link set");
    write(1, 9'h1C3);
    check("R6 right write under link");
    write(3, 9'h000);
    check("R6 link clear");

    for (int d = 0; d < 512; d++) begin
      write(2, 9'(d));
      check("R7 addr2 sweep");
    end
    for (int d = 0; d < 512; d++) begin
      write(3, 9'(d));
      check("R8 addr3 sweep");
    end

    for (int a = 9; a < 16; a++) begin
      write(a, 9'h1FF ^ 9'(a));
      check("R9 unused address");
    end

    send_bits({17'h0, 4'd0, 9'h100}, 15);
    check("R10 short frame");
    send_bits({4'hA, 3'b011, 4'd5, 9'h1E1}, 20);
    model_write(5, 9'h1E1);
    check("R2 long frame keeps last 16 bits");

    write(2, 9'h0FF);
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    model_reset();
    check("R11 async reset");
    wait_clk(3); @(negedge clk);
    rst_n = 1'b1;
    wait_clk(2); @(negedge clk);
    check("R11 after release");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_clk(190000);
    n_bad++;
    $display("FAIL watchdog R2 act=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule